// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block holds the software-visible control state for two storage bus-master DMA channels. All of it sits in one 16-byte I/O window. Each channel takes 8 bytes of the window. The low half of a channel's slot carries a command byte and a status byte, and these accept single-byte accesses only. The high half carries a 32-bit descriptor-table pointer, which accepts byte, halfword and word accesses.

The host side is a plain strobe interface. On a write, `wr_en`, `addr`, `size` and `wdata` are presented together for one cycle. On a read, `rd_en`, `addr` and `size` are presented for one cycle, and the result appears on `rdata` with `rd_valid` one cycle later. The engine side receives a start pulse, a direction level and the aligned table address for each channel. It returns completion, error and interrupt events, which update the status byte.

The status byte holds three kinds of bit. Bit 0 is the activity flag, which software cannot write. Bits 1 and 2 are the error and interrupt flags, which software clears by writing a one. Bits 5 and 6 are plain storage bits. Every other status bit reads as zero.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset, every command, status and pointer register of both channels reads zero, and `dma_start`, `dma_dir` and `dma_table` are all zero.
- R2: Channel n occupies addresses 8n to 8n+7. In each slot the command byte is at offset 0, the status byte at offset 2 and the pointer at offsets 4 to 7. Read data appears on `rdata` one cycle after `rd_en`, with `rd_valid` high in that cycle and unused upper bits zero.
- R3: A byte read at offset 1 or offset 3 of a channel slot returns 0xFF.
- R4: A read at offsets 0 to 3 whose size code is not 0 returns all ones for the access width. Size code 1 (two bytes) gives 0x0000FFFF, and codes 2 and 3 (four bytes) give 0xFFFFFFFF.
- R5: A write at offsets 0 to 3 whose size code is not 0 changes nothing. A byte write at offset 1 or offset 3 changes nothing.
- R6: A byte write to status loads bits 5 and 6 from the data. It leaves bit 0 unchanged, clears bit 1 and bit 2 where the data holds a one, and leaves bits 3, 4 and 7 at zero.
- R7: The command byte stores only bit 0 (start) and bit 3 (direction), and all other bits read zero. A write that takes bit 0 from 0 to 1 gives a one-cycle pulse on that channel's `dma_start` bit and sets status bit 0. `dma_dir` follows command bit 3.
- R8: Clearing command bit 0 leaves status bit 0 set. A cycle with `ev_done` high clears status bit 0.
- R9: `ev_err` sets status bit 1 and `ev_irq` sets status bit 2. When an event and a software clear of the same bit fall in the same cycle, the bit ends set.
- R10: Pointer writes update byte lanes k to k+w-1, where k is the offset minus 4 and w is the access width (code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). The data is taken from the low end of `wdata`. Pointer bits 1:0 always read zero, and `dma_table` carries the pointer.
- R11: A pointer read returns the pointer shifted right by 8k bits and masked to the access width.
- R12: An access to one channel never changes the registers or outputs of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte address within the window |
| size | input | 2 | Access width code: 0 = byte, 1 = halfword, 2 or 3 = word |
| wdata | input | 32 | Write data, low-aligned |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| ev_done | input | 2 | Per-channel transfer completion event |
| ev_err | input | 2 | Per-channel error event |
| ev_irq | input | 2 | Per-channel interrupt event |
| dma_start | output | 2 | Per-channel one-cycle start pulse |
| dma_dir | output | 2 | Per-channel transfer direction |
| dma_table | output | 64 | Descriptor-table addresses, channel 0 in the low 32 bits |

## Verification
The embedded properties assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that the event inputs behave as single-cycle flags that may coincide with a software access. Each driver task issues exactly one strobe and holds it for exactly one clock, so no two host accesses overlap. Events are raised only inside such a window, and only where a test means them to collide with a write, as in the set-against-clear case.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

   localparam int unsigned SLOT_BYTES = 8;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_WORD3 = 2'b11
   } acc_size_e;

   // byte-lane mask of an access starting at lane 0
   function automatic logic [3:0] size_lanes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: size_lanes = 4'b0001;
         SZ_HALF: size_lanes = 4'b0011;
         default: size_lanes = 4'b1111;
      endcase
   endfunction

   // all-ones pattern covering the access width
   function automatic logic [31:0] size_mask(input logic [1:0] sz);
      size_mask = {{16{sz[1]}}, {8{sz[1] | sz[0]}}, 8'hFF};
   endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
   import bmdma_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned AW     = 4
) (
   input  logic                       wr_en,
   input  logic [AW-1:0]              addr,
   input  logic [1:0]                 size,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_CH-1:0]          cmd_we,
   output logic [NUM_CH-1:0]          sts_we,
   output logic [NUM_CH*(DATA_W/8)-1:0] ptr_be,
   output logic [DATA_W-1:0]          ptr_wd,
   output logic [7:0]                 wbyte
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned CHW   = AW - 3;

   logic [CHW-1:0] ch;
   logic           in_ptr;
   logic [1:0]     off;
   logic           is_byte;
   logic [6:0]     span;

   assign ch      = addr[AW-1:3];
   assign in_ptr  = addr[2];
   assign off     = addr[1:0];
   assign is_byte = (size == SZ_BYTE);
   assign span    = {3'b000, size_lanes(size)} << off;
   assign ptr_wd  = wdata << {off, 3'b000};
   assign wbyte   = wdata[7:0];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit;
      assign hit = wr_en && (ch == CHW'(g));
      assign cmd_we[g] = hit && !in_ptr && is_byte && (off == 2'd0);
      assign sts_we[g] = hit && !in_ptr && is_byte && (off == 2'd2);
      assign ptr_be[g*LANES +: LANES] = (hit && in_ptr) ? span[LANES-1:0] : '0;
   end

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
   import bmdma_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter bit          ALIGN_PTR = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_we,
   input  logic                  sts_we,
   input  logic [7:0]            wbyte,
   input  logic [DATA_W/8-1:0]   ptr_be,
   input  logic [DATA_W-1:0]     ptr_wd,
   input  logic                  ev_done,
   input  logic                  ev_err,
   input  logic                  ev_irq,
   output logic [7:0]            cmd_q,
   output logic [7:0]            sts_q,
   output logic [DATA_W-1:0]     ptr_q,
   output logic                  start_o,
   output logic                  dir_o
);
   localparam int unsigned LANES    = DATA_W / 8;
   localparam int unsigned START_B  = 0;
   localparam int unsigned DIR_B    = 3;
   localparam int unsigned ACT_B    = 0;
   localparam int unsigned ERR_B    = 1;
   localparam int unsigned IRQ_B    = 2;
   localparam logic [7:0]  CMD_KEEP = 8'h09;
   localparam logic [7:0]  STS_RW   = 8'h60;
   localparam logic [7:0]  STS_W1C  = 8'h06;
   localparam logic [7:0]  STS_RO   = 8'h01;
   localparam logic [7:0]  STS_ZERO = ~(STS_RW | STS_W1C | STS_RO);

   logic              go;
   logic [7:0]        sts_d;
   logic [DATA_W-1:0] ptr_merged;
   logic [DATA_W-1:0] ptr_d;

   assign go = cmd_we && wbyte[START_B] && !cmd_q[START_B];

   always_comb begin
      sts_d = sts_q;
      if (sts_we)
         sts_d = (wbyte & STS_RW) | (sts_q & STS_RO) | (sts_q & ~wbyte & STS_W1C);
      if (ev_done) sts_d[ACT_B] = 1'b0;
      if (go)      sts_d[ACT_B] = 1'b1;
      if (ev_err)  sts_d[ERR_B] = 1'b1;
      if (ev_irq)  sts_d[IRQ_B] = 1'b1;
   end

   always_comb begin
      ptr_merged = ptr_q;
      for (int j = 0; j < LANES; j++)
         if (ptr_be[j]) ptr_merged[8*j +: 8] = ptr_wd[8*j +: 8];
   end

   if (ALIGN_PTR) begin : g_align
      assign ptr_d = {ptr_merged[DATA_W-1:2], 2'b00};
   end else begin : g_raw
      assign ptr_d = ptr_merged;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         sts_q   <= '0;
         ptr_q   <= '0;
         start_o <= 1'b0;
      end else begin
         if (cmd_we) cmd_q <= wbyte & CMD_KEEP;
         sts_q   <= sts_d;
         ptr_q   <= ptr_d;
         start_o <= go;
      end
   end

   assign dir_o = cmd_q[DIR_B];

   // R7
   start_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (sts_q[ACT_B] && start_o && cmd_q[START_B]));

   // R7
   start_is_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   // R8
   done_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_done && !go) |=> !sts_q[ACT_B]);

   // R9
   err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_err |=> sts_q[ERR_B]);

   // R9
   irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_irq |=> sts_q[IRQ_B]);

   // R6
   active_not_writable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && !go && !ev_done) |=> $stable(sts_q[ACT_B]));

   // R6
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q & STS_ZERO) == 8'h00);

   // R10
   if (ALIGN_PTR) begin : g_align_chk
      ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ptr_q[1:0] == 2'b00);
   end

endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
   import bmdma_pkg::*;
#(
   parameter int unsigned NUM_CH    = 2,
   parameter int unsigned DATA_W    = 32,
   parameter bit          ALIGN_PTR = 1'b1,
   localparam int unsigned AW       = $clog2(NUM_CH * SLOT_BYTES),
   localparam int unsigned LANES    = DATA_W / 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [AW-1:0]            addr,
   input  logic [1:0]               size,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   output logic                     rd_valid,
   input  logic [NUM_CH-1:0]        ev_done,
   input  logic [NUM_CH-1:0]        ev_err,
   input  logic [NUM_CH-1:0]        ev_irq,
   output logic [NUM_CH-1:0]        dma_start,
   output logic [NUM_CH-1:0]        dma_dir,
   output logic [NUM_CH*DATA_W-1:0] dma_table
);
   localparam int unsigned CHW = AW - 3;

   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (DATA_W != 32) begin : g_bad_w
      $error("DATA_W must be 32");
   end

   logic [NUM_CH-1:0]       cmd_we;
   logic [NUM_CH-1:0]       sts_we;
   logic [NUM_CH*LANES-1:0] ptr_be;
   logic [DATA_W-1:0]       ptr_wd;
   logic [7:0]              wbyte;
   logic [7:0]              cmd_q [NUM_CH];
   logic [7:0]              sts_q [NUM_CH];
   logic [DATA_W-1:0]       ptr_q [NUM_CH];

   bmdma_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .AW(AW)) u_dec (
      .wr_en  (wr_en),
      .addr   (addr),
      .size   (size),
      .wdata  (wdata),
      .cmd_we (cmd_we),
      .sts_we (sts_we),
      .ptr_be (ptr_be),
      .ptr_wd (ptr_wd),
      .wbyte  (wbyte)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      bmdma_chan #(.DATA_W(DATA_W), .ALIGN_PTR(ALIGN_PTR)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .cmd_we  (cmd_we[g]),
         .sts_we  (sts_we[g]),
         .wbyte   (wbyte),
         .ptr_be  (ptr_be[g*LANES +: LANES]),
         .ptr_wd  (ptr_wd),
         .ev_done (ev_done[g]),
         .ev_err  (ev_err[g]),
         .ev_irq  (ev_irq[g]),
         .cmd_q   (cmd_q[g]),
         .sts_q   (sts_q[g]),
         .ptr_q   (ptr_q[g]),
         .start_o (dma_start[g]),
         .dir_o   (dma_dir[g])
      );
      assign dma_table[g*DATA_W +: DATA_W] = ptr_q[g];
   end

   // read path
   logic [CHW-1:0]    rch;
   logic [1:0]        roff;
   logic [DATA_W-1:0] wmask;
   logic [DATA_W-1:0] rd_next;

   assign rch   = addr[AW-1:3];
   assign roff  = addr[1:0];
   assign wmask = size_mask(size);

   always_comb begin
      if (addr[2]) begin
         rd_next = (ptr_q[rch] >> {roff, 3'b000}) & wmask;
      end else if (size != SZ_BYTE) begin
         rd_next = wmask;
      end else begin
         case (roff)
            2'd0:    rd_next = {{(DATA_W-8){1'b0}}, cmd_q[rch]};
            2'd2:    rd_next = {{(DATA_W-8){1'b0}}, sts_q[rch]};
            default: rd_next = {{(DATA_W-8){1'b0}}, 8'hFF};
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rdata <= rd_next;
      end
   end

   // R2
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // R4
   wide_ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !addr[2] && size[1]) |=> (rdata == '1));

   // R5
   wide_ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr[2] && size != SZ_BYTE) |-> (cmd_we == '0 && sts_we == '0));

   // R12
   one_channel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_we | sts_we));

endmodule

// File: tb/sim_bmdma_regfile.sv
`timescale 1ns/1ps
module sim_bmdma_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [1:0]  size = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rd_valid;
   logic [1:0]  ev_done = '0;
   logic [1:0]  ev_err = '0;
   logic [1:0]  ev_irq = '0;
   logic [1:0]  dma_start;
   logic [1:0]  dma_dir;
   logic [63:0] dma_table;

   int checks = 0;
   int errors = 0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   bmdma_regfile u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .size(size), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
      .ev_done(ev_done), .ev_err(ev_err), .ev_irq(ev_irq),
      .dma_start(dma_start), .dma_dir(dma_dir), .dma_table(dma_table)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
      addr = a; size = s; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [1:0] s, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      addr = a; size = s; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2: unexpected rd_valid, actual %h expected none", rdata);
         end else begin
            chk({32'h0, rdata}, {32'h0, exp_q.pop_front()}, tag_q.pop_front());
         end
      end
   end

   task automatic finish_run;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk({62'h0, dma_start}, 64'h0, "R1 start");
      chk({62'h0, dma_dir}, 64'h0, "R1 dir");
      chk(dma_table, 64'h0, "R1 table");
      rd(4'd0, 2'd0, 32'h0, "R1 cmd0");
      rd(4'd2, 2'd0, 32'h0, "R1 sts0");
      rd(4'd4, 2'd2, 32'h0, "R1 ptr0");

      // R3 filler offsets, R2 second slot
      rd(4'd1, 2'd0, 32'hFF, "R3 ch0 off1");
      rd(4'd3, 2'd0, 32'hFF, "R3 ch0 off3");
      rd(4'd9, 2'd0, 32'hFF, "R3 ch1 off1");
      rd(4'd11, 2'd0, 32'hFF, "R3 ch1 off3");

      // R4 wide reads of control half
      rd(4'd0, 2'd1, 32'h0000FFFF, "R4 half");
      rd(4'd2, 2'd2, 32'hFFFFFFFF, "R4 word");
      rd(4'd2, 2'd3, 32'hFFFFFFFF, "R4 word code3");

      // R7 start and direction
      wr(4'd0, 2'd0, 32'hFF);
      chk({62'h0, dma_start}, 64'h1, "R7 start pulse");
      chk({62'h0, dma_dir}, 64'h1, "R7 dir");
      @(negedge clk);
      chk({62'h0, dma_start}, 64'h0, "R7 pulse ends");
      rd(4'd0, 2'd0, 32'h09, "R7 cmd stored bits");
      rd(4'd2, 2'd0, 32'h01, "R7 active set");

      // R6 status write semantics
      wr(4'd2, 2'd0, 32'hFF);
      rd(4'd2, 2'd0, 32'h61, "R6 write ff");
      wr(4'd2, 2'd0, 32'h00);
      rd(4'd2, 2'd0, 32'h01, "R6 write 00");

      // R5 ignored writes
      wr(4'd0, 2'd1, 32'h0);
      rd(4'd0, 2'd0, 32'h09, "R5 wide cmd write");
      wr(4'd1, 2'd0, 32'h00);
      wr(4'd3, 2'd0, 32'hFF);
      wr(4'd2, 2'd2, 32'h60);
      rd(4'd0, 2'd0, 32'h09, "R5 off1 write");
      rd(4'd2, 2'd0, 32'h01, "R5 off3 and wide sts write");

      // R8 stop and done
      wr(4'd0, 2'd0, 32'h08);
      chk({62'h0, dma_start}, 64'h0, "R8 no pulse on stop");
      rd(4'd2, 2'd0, 32'h01, "R8 active kept on stop");
      ev_done[0] = 1'b1; @(negedge clk); ev_done[0] = 1'b0;
      rd(4'd2, 2'd0, 32'h00, "R8 done clears active");
      rd(4'd0, 2'd0, 32'h08, "R8 cmd after stop");

      // R9 events and set-over-clear
      ev_err[0] = 1'b1; @(negedge clk); ev_err[0] = 1'b0;
      rd(4'd2, 2'd0, 32'h02, "R9 err sets");
      ev_irq[0] = 1'b1; @(negedge clk); ev_irq[0] = 1'b0;
      rd(4'd2, 2'd0, 32'h06, "R9 irq sets");
      wr(4'd2, 2'd0, 32'h02);
      rd(4'd2, 2'd0, 32'h04, "R6 w1c err");
      ev_err[0] = 1'b1; @(negedge clk); ev_err[0] = 1'b0;
      ev_irq[0] = 1'b1;
      wr(4'd2, 2'd0, 32'h06);
      ev_irq[0] = 1'b0;
      rd(4'd2, 2'd0, 32'h04, "R9 set wins");

      // R10 / R11 pointer
      wr(4'd4, 2'd2, 32'h12345677);
      rd(4'd4, 2'd2, 32'h12345674, "R10 word write aligned");
      chk({32'h0, dma_table[31:0]}, 64'h12345674, "R10 table out");
      wr(4'd6, 2'd0, 32'hAB);
      rd(4'd4, 2'd2, 32'h12AB5674, "R10 byte lane 2");
      wr(4'd6, 2'd1, 32'hBEEF);
      rd(4'd4, 2'd2, 32'hBEEF5674, "R10 half upper");
      rd(4'd5, 2'd0, 32'h56, "R11 byte read");
      rd(4'd6, 2'd1, 32'hBEEF, "R11 half read");
      wr(4'd4, 2'd0, 32'h03);
      rd(4'd4, 2'd2, 32'hBEEF5600, "R10 low bits forced");
      rd(4'd7, 2'd0, 32'hBE, "R11 top byte");

      // R12 channel independence
      rd(4'd8, 2'd0, 32'h0, "R12 cmd1 untouched");
      rd(4'd10, 2'd0, 32'h0, "R12 sts1 untouched");
      rd(4'd12, 2'd2, 32'h0, "R12 ptr1 untouched");
      wr(4'd8, 2'd0, 32'h01);
      chk({62'h0, dma_start}, 64'h2, "R12 ch1 start only");
      chk({62'h0, dma_dir}, 64'h1, "R12 dir per channel");
      rd(4'd10, 2'd0, 32'h01, "R12 sts1 active");
      rd(4'd2, 2'd0, 32'h04, "R12 sts0 kept");
      wr(4'd12, 2'd2, 32'hFFFFFFFF);
      chk(dma_table, 64'hFFFFFFFC_BEEF5600, "R12 table both");

      repeat (3) @(negedge clk);
      chk({63'h0, exp_q.size() == 0}, 64'h1, "R2 all reads answered");
      finish_run();
   end

endmodule